// File: doc/BRIEF.md
# Packed float compare and select unit

This unit takes two 64-bit operands. Each operand carries two single-precision floating-point lanes, and the unit works on both lanes at once. Lane 0 sits in bits 31:0 and lane 1 in bits 63:32. A 3-bit operation select picks what the unit does:

- Three compare operations (equal, greater-or-equal, greater-than) turn each lane into a full-width mask, all ones or all zeros.
- Maximum and minimum use the same ordering logic to pick one of the two input lanes.
- A swap exchanges the two 32-bit halves of the second operand.

Operands and select are captured on a valid strobe. The result appears on the output one clock edge later, together with a one-cycle valid pulse. The result then holds until the next strobe.

Ordering comes from the bit patterns alone, with no arithmetic:

- Sign and magnitude decide the order.
- Signed zeros and denormals count as zero.
- A NaN in either lane makes that lane unordered.

The unit is meant for a packed-SIMD execute stage. It is a single-cycle compare and select with a registered result.

Top module: `pkfcmp_unit`

## Requirements
- R1: After reset is asserted (rst_ni low), valid_o is 0 and result_o is all zeros.
- R2: A strobe on valid_i at a clock edge makes valid_o high for exactly the next cycle, with result_o holding the answer. Without a strobe, valid_o is low and result_o keeps its previous value.
- R3: Lane 0 (bits 31:0) and lane 1 (bits 63:32) are evaluated independently, so each lane may produce a different outcome in the same operation.
- R4: Select code 3'b000 (equal) makes a lane 32'hFFFFFFFF when the first-operand lane equals the second-operand lane, and 32'h00000000 otherwise.
- R5: Select codes 3'b001 (first greater-or-equal to second) and 3'b010 (first strictly greater than second) produce masks in the same all-ones/all-zeros form.
- R6: Ordering works as follows:
  - a positive value exceeds any negative value;
  - two positive values order as unsigned integers of bits 30:0;
  - two negative values order in reverse of that;
  - infinities (exponent 8'hFF, mantissa 0) take part as ordinary largest magnitudes.
- R7: A lane with exponent field (bits 30:23) equal to 0 counts as zero whatever its sign and mantissa. So +0, -0 and denormals all compare equal to one another.
- R8: A lane is NaN when its exponent is 8'hFF and its mantissa (bits 22:0) is non-zero. If either lane is NaN, codes 3'b000, 3'b001 and 3'b010 give 32'h00000000 for that lane.
- R9: Select code 3'b011 (maximum) returns the first-operand lane when it is strictly greater than the second, and the second-operand lane otherwise. This includes the equal and NaN cases.
- R10: Select code 3'b100 (minimum) returns the first-operand lane when it is strictly less than the second, and the second-operand lane otherwise. This includes the equal and NaN cases.
- R11: Select code 3'b101 (swap) places second-operand bits 31:0 in result bits 63:32, and second-operand bits 63:32 in result bits 31:0.
- R12: Select codes 3'b110 and 3'b111 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that captures a new operation |
| op_i | input | 3 | Operation select |
| a_i | input | 64 | First operand, two float lanes |
| b_i | input | 64 | Second operand, two float lanes |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| result_o | output | 64 | Registered result |

## Verification
Two things can happen in the same cycle. First, the two lanes can take different outcomes within one operation: one lane may be unordered while the other is ordinary, or one lane may be equal while the other is strictly ordered. The stimulus pairs such lanes deliberately, and each half of the result is checked against its own expected value. Second, a strobe can arrive in the cycle right after another strobe. The bench issues back-to-back strobes and expects each result in the cycle after its own strobe, with no mixing of operand or select values between them.

// File: rtl/pkfcmp_pkg.sv
package pkfcmp_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned MAN_W  = 23;
  localparam int unsigned LANE_W = 1 + EXP_W + MAN_W;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_EQ   = 3'd0,
    OP_GE   = 3'd1,
    OP_GT   = 3'd2,
    OP_MAX  = 3'd3,
    OP_MIN  = 3'd4,
    OP_SWAP = 3'd5
  } op_e;
endpackage

// File: rtl/fp_lane_order.sv
module fp_lane_order #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o,
  output logic         gt_o,
  output logic         lt_o,
  output logic         unord_o
);
  logic [EXP_W-1:0] exp_a, exp_b;
  logic [MAN_W-1:0] man_a, man_b;
  logic             nan_a, nan_b, zero_a, zero_b;
  logic             sgn_a, sgn_b;
  logic [W-2:0]     mag_a, mag_b;
  logic             eq_raw, gt_raw;

  assign exp_a  = a_i[W-2 -: EXP_W];
  assign exp_b  = b_i[W-2 -: EXP_W];
  assign man_a  = a_i[MAN_W-1:0];
  assign man_b  = b_i[MAN_W-1:0];
  assign nan_a  = (&exp_a) && (|man_a);
  assign nan_b  = (&exp_b) && (|man_b);
  // denormals and signed zeros fold to +0
  assign zero_a = ~|exp_a;
  assign zero_b = ~|exp_b;
  assign sgn_a  = zero_a ? 1'b0 : a_i[W-1];
  assign sgn_b  = zero_b ? 1'b0 : b_i[W-1];
  assign mag_a  = zero_a ? '0 : a_i[W-2:0];
  assign mag_b  = zero_b ? '0 : b_i[W-2:0];

  always_comb begin
    if (sgn_a != sgn_b) begin
      eq_raw = 1'b0;
      gt_raw = ~sgn_a;
    end else begin
      eq_raw = (mag_a == mag_b);
      gt_raw = sgn_a ? (mag_a < mag_b) : (mag_a > mag_b);
    end
  end

  assign unord_o = nan_a | nan_b;
  assign eq_o    = ~unord_o & eq_raw;
  assign gt_o    = ~unord_o & gt_raw;
  assign lt_o    = ~unord_o & ~eq_raw & ~gt_raw;
endmodule

// File: rtl/fp_lane_pick.sv
module fp_lane_pick
  import pkfcmp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [W-1:0]    swap_i,
  input  logic            eq_i,
  input  logic            gt_i,
  input  logic            lt_i,
  output logic [W-1:0]    res_o
);
  always_comb begin
    case (op_e'(op_i))
      OP_EQ:   res_o = {W{eq_i}};
      OP_GE:   res_o = {W{eq_i | gt_i}};
      OP_GT:   res_o = {W{gt_i}};
      OP_MAX:  res_o = gt_i ? a_i : b_i;
      OP_MIN:  res_o = lt_i ? a_i : b_i;
      OP_SWAP: res_o = swap_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/pkfcmp_unit.sv
module pkfcmp_unit
  import pkfcmp_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic            valid_o,
  output logic [DW-1:0]   result_o
);
  logic [DW-1:0]    res_d, res_q;
  logic             vld_q;
  logic [LANES-1:0] eq, gt, lt, unord;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned SW = LANES - 1 - l;

    fp_lane_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
      .a_i    (a_i[l*LANE_W +: LANE_W]),
      .b_i    (b_i[l*LANE_W +: LANE_W]),
      .eq_o   (eq[l]),
      .gt_o   (gt[l]),
      .lt_o   (lt[l]),
      .unord_o(unord[l])
    );

    fp_lane_pick #(.W(LANE_W)) u_pick (
      .op_i  (op_i),
      .a_i   (a_i[l*LANE_W +: LANE_W]),
      .b_i   (b_i[l*LANE_W +: LANE_W]),
      .swap_i(b_i[SW*LANE_W +: LANE_W]),
      .eq_i  (eq[l]),
      .gt_i  (gt[l]),
      .lt_i  (lt[l]),
      .res_o (res_d[l*LANE_W +: LANE_W])
    );

    a_r6_order_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({eq[l], gt[l], lt[l], unord[l]}) == 1);

    a_r8_nan_no_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && unord[l] && (op_i <= 3'd2) |=> result_o[l*LANE_W +: LANE_W] == '0);

    a_r5_mask_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && (op_i <= 3'd2) |=>
        (result_o[l*LANE_W +: LANE_W] == '0) || (&result_o[l*LANE_W +: LANE_W]));

    a_r9_max_picks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && (op_i == 3'd3) |=>
        (result_o[l*LANE_W +: LANE_W] == $past(a_i[l*LANE_W +: LANE_W])) ||
        (result_o[l*LANE_W +: LANE_W] == $past(b_i[l*LANE_W +: LANE_W])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = vld_q;
  assign result_o = res_q;

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o));

  a_r11_swap_halves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'd5) |=>
      result_o == {$past(b_i[LANE_W-1:0]), $past(b_i[DW-1:DW-LANE_W])});

  a_r12_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i > 3'd5) |=> result_o == '0);
endmodule

// File: tb/pkfcmp_unit_bench.sv
module pkfcmp_unit_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R4 R3: lane1 equal, lane0 not
    '{3'd0, 64'h3F800000_40000000, 64'h3F800000_3F800000, 64'hFFFFFFFF_00000000},
    // R7: +0 vs -0, denormal vs negative denormal
    '{3'd0, 64'h00000000_00000001, 64'h80000000_80000005, 64'hFFFFFFFF_FFFFFFFF},
    // R8: NaN in either lane
    '{3'd0, 64'h7FC00000_7FC00000, 64'h7FC00000_3F800000, 64'h00000000_00000000},
    // R5 GE true both lanes, negatives
    '{3'd1, 64'h3F800000_BF800000, 64'h3F800000_C0000000, 64'hFFFFFFFF_FFFFFFFF},
    '{3'd1, 64'hC0000000_3F800000, 64'hBF800000_40000000, 64'h00000000_00000000},
    // R5 R3 GT: lane1 equal, lane0 greater
    '{3'd2, 64'h3F800000_BF800000, 64'h3F800000_C0000000, 64'h00000000_FFFFFFFF},
    // R6: infinities
    '{3'd2, 64'h7F800000_3F800000, 64'h40000000_FF800000, 64'hFFFFFFFF_FFFFFFFF},
    // R8 R7 GT: NaN lane, -0 vs +0
    '{3'd2, 64'h7FC00000_80000000, 64'h3F800000_00000000, 64'h00000000_00000000},
    // R6: one ulp apart, smallest normal over denormal
    '{3'd2, 64'h3F800001_00800000, 64'h3F800000_00000001, 64'hFFFFFFFF_FFFFFFFF},
    // R6: negatives reverse order
    '{3'd2, 64'hBF800000_C0000000, 64'hBF800001_BF800000, 64'hFFFFFFFF_00000000},
    // R9 MAX
    '{3'd3, 64'h40000000_C0000000, 64'h3F800000_BF800000, 64'h40000000_BF800000},
    // R9: NaN and equal zeros give second operand
    '{3'd3, 64'h7FC00000_00000000, 64'h3F800000_80000000, 64'h3F800000_80000000},
    // R10 MIN
    '{3'd4, 64'h40000000_C0000000, 64'h3F800000_BF800000, 64'h3F800000_C0000000},
    // R10: NaN and denormal-equal give second operand
    '{3'd4, 64'h3F800000_00000001, 64'h7FC00000_00000000, 64'h7FC00000_00000000},
    // R11 swap
    '{3'd5, 64'h12345678_9ABCDEF0, 64'h11111111_22222222, 64'h22222222_11111111},
    // R12 reserved
    '{3'd6, 64'h3F800000_3F800000, 64'h3F800000_3F800000, 64'h00000000_00000000},
    '{3'd5, 64'h0, 64'hAAAA5555_CAFEF00D, 64'hCAFEF00D_AAAA5555},
    '{3'd7, 64'h3F800000_3F800000, 64'h3F800000_3F800000, 64'h00000000_00000000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pkfcmp_unit u_pkfcmp_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i, .valid_o, .result_o
  );

  function automatic string op_req(logic [2:0] op);
    case (op)
      3'd0: return "R4 equal";
      3'd1: return "R5 ge";
      3'd2: return "R5 gt";
      3'd3: return "R9 max";
      3'd4: return "R10 min";
      3'd5: return "R11 swap";
      default: return "R12 reserved";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check("R1 valid", {63'd0, valid_o}, 64'd0);
    check("R1 result", result_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      strobe(VECS[i].op, VECS[i].a, VECS[i].b);
      @(negedge clk_i);
      valid_i = 1'b0;
      check("R2 valid pulse", {63'd0, valid_o}, 64'd1);
      check(op_req(VECS[i].op), result_o, VECS[i].exp);
    end

    // R2 idle: valid low, result held
    @(negedge clk_i);
    check("R2 idle valid", {63'd0, valid_o}, 64'd0);
    check("R2 idle hold", result_o, 64'd0);
    a_i = 64'h40000000_40000000; b_i = 64'h40000000_40000000; op_i = 3'd0;
    @(negedge clk_i);
    check("R2 no strobe ignores inputs", result_o, 64'd0);

    // R2 back-to-back strobes
    strobe(3'd3, 64'h40000000_3F800000, 64'h3F800000_40000000);
    @(negedge clk_i);
    check("R2 b2b first valid", {63'd0, valid_o}, 64'd1);
    check("R9 b2b first", result_o, 64'h40000000_40000000);
    strobe(3'd4, 64'h40000000_3F800000, 64'h3F800000_40000000);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2 b2b second valid", {63'd0, valid_o}, 64'd1);
    check("R10 b2b second", result_o, 64'h3F800000_3F800000);
    @(negedge clk_i);
    check("R2 after b2b valid", {63'd0, valid_o}, 64'd0);
    check("R2 after b2b hold", result_o, 64'h3F800000_3F800000);

    // R1 reset mid-run clears result
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset clears", result_o, 64'd0);
    check("R1 reset valid", {63'd0, valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule